// File: doc/BRIEF.md
# Encoded Microcode Sequencer

This block is the next-state engine of a microcoded processor controller. It keeps a 6-bit micro-program counter and reads a synthesizable control store. Each microword holds 18 datapath control lines and a 3-bit jump code. The microword does not hold a full next address. The jump code picks one of a few successors instead: the following word, the same word while memory is busy, the fetch entry, the start of the routine for the current macro-opcode, or a conditional return to fetch.

The control store holds these routines:
- instruction fetch
- register-register ALU
- register-immediate ALU
- word load
- jump-and-link
- conditional branch
- memory-to-memory add

A small decoder maps the 5-bit macro-opcode (instruction bits 6..2) to a routine start address. An opcode it does not know sends the sequencer to a halt word, and the sequencer stays there until reset.

The datapath sits outside this block. It receives `ctrl_o`, and it returns the memory-busy and condition flags. The `ftrue` jump kind is available in the next-address logic. The shipped routines do not use it.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `upc_o` is 0 (fetch0). After release, sequencing starts from 0.
- R2: A word with jump kind NEXT moves `upc_o` to its own address plus one on the next clock.
- R3: A word with jump kind SPIN keeps `upc_o` unchanged while `busy_i` is 1. It advances by one on the first clock where `busy_i` is 0.
- R4: A word with jump kind FETCH moves `upc_o` to 0 on the next clock.
- R5: The DISPATCH word (address 2) jumps according to `opcode_i` sampled in that cycle. The opcode-to-address mapping is:
  - 01100 goes to 3
  - 00100 goes to 6
  - 00000 goes to 9
  - 11011 goes to 14
  - 11000 goes to 19
  - 00010 goes to 25

  `opcode_i` has no effect in any other cycle.
- R6: Any other opcode at dispatch moves `upc_o` to 32. `upc_o` then stays at 32, whatever the inputs, until reset.
- R7: The FFALSE word (address 21) goes to 0 when `cond_i` is 0, and goes to 22 when `cond_i` is 1.
- R8: The routine layout and jump kinds are fixed, as listed below (N=next, S=spin, F=fetch):

  | Routine | Addresses | Jump kinds |
  |---|---|---|
  | fetch | 0-2 | N, S, dispatch |
  | ALU | 3-5 | N, N, F |
  | ALUI | 6-8 | N, N, F |
  | load | 9-13 | N, N, N, S, F |
  | JAL | 14-18 | N, N, N, N, F |
  | branch | 19-24 | N, N, FFALSE, N, N, F |
  | mem-mem add | 25-31 | N, S, N, S, N, S, F |

- R9: `ctrl_o` bit layout, MSB to LSB:
  - 17 ld_ma, 16 ld_a, 15 ld_b, 14 ld_ir
  - 13 reg_wr, 12 mem_wr
  - 11 reg_en, 10 mem_en, 9 alu_en, 8 imm_en
  - 7:5 alu op: 0 add, 1 minus4, 2 plus4, 3 instruction op, 4 pass A
  - 4:3 register select: 0 pc, 1 rs1, 2 rs2, 3 rd
  - 2:0 immediate kind: 0 none, 1 I, 2 B, 3 J

  Fetch0 drives 0x30800. Fetch1 drives 0x04400. The add write step (address 30) drives 0x01260.
- R10: The halt word (address 32) drives `ctrl_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 5 | Macro-opcode field, used at dispatch |
| busy_i | input | 1 | Memory busy flag |
| cond_i | input | 1 | Branch condition flag |
| upc_o | output | 6 | Current micro-program counter |
| ctrl_o | output | 18 | Control lines of the current microword |

## Verification
A corrupted micro-PC shows on `upc_o` in the same cycle. A wrong jump kind or a wrong dispatch target shows one clock after the word that caused it. After that, every later address departs from the expected path. A spin that ignores busy, or a halt that leaks, shows within one clock of the offending input. The bench follows the expected address on every clock with randomized busy, condition and off-dispatch opcode values. Because of that, a single mis-step is caught at the cycle where it occurs.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int UPC_W  = 6;
    localparam int OPC_W  = 5;
    localparam int CTRL_W = 18;

    typedef enum logic [2:0] {
        J_NEXT   = 3'd0,
        J_SPIN   = 3'd1,
        J_FETCH  = 3'd2,
        J_DISP   = 3'd3,
        J_FTRUE  = 3'd4,
        J_FFALSE = 3'd5,
        J_PARK   = 3'd6
    } jump_e;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB4  = 3'd1,
        ALU_INC4  = 3'd2,
        ALU_FUNC  = 3'd3,
        ALU_PASSA = 3'd4
    } alu_e;

    typedef enum logic [1:0] {
        RS_PC  = 2'd0,
        RS_RS1 = 2'd1,
        RS_RS2 = 2'd2,
        RS_RD  = 2'd3
    } rsel_e;

    typedef enum logic [2:0] {
        IM_NONE = 3'd0,
        IM_I    = 3'd1,
        IM_B    = 3'd2,
        IM_J    = 3'd3
    } imm_e;

    typedef struct packed {
        logic  ld_ma;
        logic  ld_a;
        logic  ld_b;
        logic  ld_ir;
        logic  reg_wr;
        logic  mem_wr;
        logic  en_reg;
        logic  en_mem;
        logic  en_alu;
        logic  en_imm;
        alu_e  alu;
        rsel_e rsel;
        imm_e  imm;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        jump_e jump;
    } uword_t;

    // Routine entry points
    localparam int A_FETCH = 0;
    localparam int A_ALU   = 3;
    localparam int A_ALUI  = 6;
    localparam int A_LW    = 9;
    localparam int A_JAL   = 14;
    localparam int A_BR    = 19;
    localparam int A_MMA   = 25;
    localparam int A_HALT  = 32;

    // Macro-opcode groups (instruction bits 6..2)
    localparam logic [OPC_W-1:0] OPC_ALU  = 5'b01100;
    localparam logic [OPC_W-1:0] OPC_ALUI = 5'b00100;
    localparam logic [OPC_W-1:0] OPC_LOAD = 5'b00000;
    localparam logic [OPC_W-1:0] OPC_JAL  = 5'b11011;
    localparam logic [OPC_W-1:0] OPC_BR   = 5'b11000;
    localparam logic [OPC_W-1:0] OPC_MMA  = 5'b00010;
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int UPC_W = useq_pkg::UPC_W
) (
    input  logic [UPC_W-1:0] upc_i,
    output uword_t           word_o
);
    uword_t w;

    always_comb begin
        w      = '0;
        w.jump = J_PARK;
        case (int'(upc_i))
            // fetch
            A_FETCH + 0: begin w.ctrl.rsel = RS_PC; w.ctrl.en_reg = 1'b1;
                               w.ctrl.ld_ma = 1'b1; w.ctrl.ld_a = 1'b1; w.jump = J_NEXT; end
            A_FETCH + 1: begin w.ctrl.en_mem = 1'b1; w.ctrl.ld_ir = 1'b1; w.jump = J_SPIN; end
            A_FETCH + 2: begin w.ctrl.alu = ALU_INC4; w.ctrl.en_alu = 1'b1;
                               w.ctrl.rsel = RS_PC; w.ctrl.reg_wr = 1'b1; w.jump = J_DISP; end
            // register-register ALU
            A_ALU + 0:   begin w.ctrl.rsel = RS_RS1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1; w.jump = J_NEXT; end
            A_ALU + 1:   begin w.ctrl.rsel = RS_RS2; w.ctrl.en_reg = 1'b1; w.ctrl.ld_b = 1'b1; w.jump = J_NEXT; end
            A_ALU + 2:   begin w.ctrl.alu = ALU_FUNC; w.ctrl.en_alu = 1'b1;
                               w.ctrl.rsel = RS_RD; w.ctrl.reg_wr = 1'b1; w.jump = J_FETCH; end
            // register-immediate ALU
            A_ALUI + 0:  begin w.ctrl.rsel = RS_RS1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1; w.jump = J_NEXT; end
            A_ALUI + 1:  begin w.ctrl.imm = IM_I; w.ctrl.en_imm = 1'b1; w.ctrl.ld_b = 1'b1; w.jump = J_NEXT; end
            A_ALUI + 2:  begin w.ctrl.alu = ALU_FUNC; w.ctrl.en_alu = 1'b1;
                               w.ctrl.rsel = RS_RD; w.ctrl.reg_wr = 1'b1; w.jump = J_FETCH; end
            // load word
            A_LW + 0:    begin w.ctrl.rsel = RS_RS1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1; w.jump = J_NEXT; end
            A_LW + 1:    begin w.ctrl.imm = IM_I; w.ctrl.en_imm = 1'b1; w.ctrl.ld_b = 1'b1; w.jump = J_NEXT; end
            A_LW + 2:    begin w.ctrl.alu = ALU_ADD; w.ctrl.en_alu = 1'b1; w.ctrl.ld_ma = 1'b1; w.jump = J_NEXT; end
            A_LW + 3:    begin w.ctrl.en_mem = 1'b1; w.ctrl.rsel = RS_RD; w.ctrl.reg_wr = 1'b1; w.jump = J_SPIN; end
            A_LW + 4:    begin w.jump = J_FETCH; end
            // jump and link
            A_JAL + 0:   begin w.ctrl.rsel = RS_PC; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1; w.jump = J_NEXT; end
            A_JAL + 1:   begin w.ctrl.alu = ALU_PASSA; w.ctrl.en_alu = 1'b1;
                               w.ctrl.rsel = RS_RD; w.ctrl.reg_wr = 1'b1; w.jump = J_NEXT; end
            A_JAL + 2:   begin w.ctrl.alu = ALU_SUB4; w.ctrl.en_alu = 1'b1; w.ctrl.ld_a = 1'b1; w.jump = J_NEXT; end
            A_JAL + 3:   begin w.ctrl.imm = IM_J; w.ctrl.en_imm = 1'b1; w.ctrl.ld_b = 1'b1; w.jump = J_NEXT; end
            A_JAL + 4:   begin w.ctrl.alu = ALU_ADD; w.ctrl.en_alu = 1'b1;
                               w.ctrl.rsel = RS_PC; w.ctrl.reg_wr = 1'b1; w.jump = J_FETCH; end
            // conditional branch
            A_BR + 0:    begin w.ctrl.rsel = RS_RS1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1; w.jump = J_NEXT; end
            A_BR + 1:    begin w.ctrl.rsel = RS_RS2; w.ctrl.en_reg = 1'b1; w.ctrl.ld_b = 1'b1; w.jump = J_NEXT; end
            A_BR + 2:    begin w.ctrl.alu = ALU_FUNC; w.ctrl.rsel = RS_PC; w.ctrl.en_reg = 1'b1;
                               w.ctrl.ld_a = 1'b1; w.jump = J_FFALSE; end
            A_BR + 3:    begin w.ctrl.alu = ALU_SUB4; w.ctrl.en_alu = 1'b1; w.ctrl.ld_a = 1'b1; w.jump = J_NEXT; end
            A_BR + 4:    begin w.ctrl.imm = IM_B; w.ctrl.en_imm = 1'b1; w.ctrl.ld_b = 1'b1; w.jump = J_NEXT; end
            A_BR + 5:    begin w.ctrl.alu = ALU_ADD; w.ctrl.en_alu = 1'b1;
                               w.ctrl.rsel = RS_PC; w.ctrl.reg_wr = 1'b1; w.jump = J_FETCH; end
            // memory-to-memory add
            A_MMA + 0:   begin w.ctrl.rsel = RS_RS1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_ma = 1'b1; w.jump = J_NEXT; end
            A_MMA + 1:   begin w.ctrl.en_mem = 1'b1; w.ctrl.ld_a = 1'b1; w.jump = J_SPIN; end
            A_MMA + 2:   begin w.ctrl.rsel = RS_RS2; w.ctrl.en_reg = 1'b1; w.ctrl.ld_ma = 1'b1; w.jump = J_NEXT; end
            A_MMA + 3:   begin w.ctrl.en_mem = 1'b1; w.ctrl.ld_b = 1'b1; w.jump = J_SPIN; end
            A_MMA + 4:   begin w.ctrl.rsel = RS_RD; w.ctrl.en_reg = 1'b1; w.ctrl.ld_ma = 1'b1; w.jump = J_NEXT; end
            A_MMA + 5:   begin w.ctrl.alu = ALU_FUNC; w.ctrl.en_alu = 1'b1; w.ctrl.mem_wr = 1'b1; w.jump = J_SPIN; end
            A_MMA + 6:   begin w.jump = J_FETCH; end
            // A_HALT and every unused address: all lines idle, parked
            default:     begin w = '0; w.jump = J_PARK; end
        endcase
    end

    assign word_o = w;
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter int UPC_W = useq_pkg::UPC_W,
    parameter int OPC_W = useq_pkg::OPC_W
) (
    input  logic [OPC_W-1:0] opcode_i,
    output logic [UPC_W-1:0] target_o
);
    always_comb begin
        case (opcode_i)
            OPC_ALU:  target_o = UPC_W'(A_ALU);
            OPC_ALUI: target_o = UPC_W'(A_ALUI);
            OPC_LOAD: target_o = UPC_W'(A_LW);
            OPC_JAL:  target_o = UPC_W'(A_JAL);
            OPC_BR:   target_o = UPC_W'(A_BR);
            OPC_MMA:  target_o = UPC_W'(A_MMA);
            default:  target_o = UPC_W'(A_HALT);
        endcase
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int UPC_W = useq_pkg::UPC_W
) (
    input  logic [UPC_W-1:0] upc_i,
    input  jump_e            jump_i,
    input  logic [UPC_W-1:0] disp_i,
    input  logic             busy_i,
    input  logic             cond_i,
    output logic [UPC_W-1:0] upc_nx_o
);
    localparam logic [UPC_W-1:0] HOME = UPC_W'(A_FETCH);
    logic [UPC_W-1:0] inc;

    always_comb begin
        inc = upc_i + 1'b1;
        case (jump_i)
            J_NEXT:   upc_nx_o = inc;
            J_SPIN:   upc_nx_o = busy_i ? upc_i : inc;
            J_FETCH:  upc_nx_o = HOME;
            J_DISP:   upc_nx_o = disp_i;
            J_FTRUE:  upc_nx_o = cond_i ? HOME : inc;
            J_FFALSE: upc_nx_o = cond_i ? inc : HOME;
            default:  upc_nx_o = upc_i;
        endcase
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int UPC_W  = useq_pkg::UPC_W,
    parameter int OPC_W  = useq_pkg::OPC_W,
    parameter int CTRL_W = useq_pkg::CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic              busy_i,
    input  logic              cond_i,
    output logic [UPC_W-1:0]  upc_o,
    output logic [CTRL_W-1:0] ctrl_o
);
    localparam logic [UPC_W-1:0] HALT_PC = UPC_W'(A_HALT);

    typedef struct packed {
        logic [UPC_W-1:0] upc;
    } state_t;

    state_t           st_d, st_q;
    uword_t           word;
    logic [UPC_W-1:0] disp_tgt;
    logic [UPC_W-1:0] upc_nx;

    useq_store #(.UPC_W(UPC_W)) u_store (
        .upc_i  (st_q.upc),
        .word_o (word)
    );

    useq_decode #(.UPC_W(UPC_W), .OPC_W(OPC_W)) u_decode (
        .opcode_i (opcode_i),
        .target_o (disp_tgt)
    );

    useq_next #(.UPC_W(UPC_W)) u_next (
        .upc_i    (st_q.upc),
        .jump_i   (word.jump),
        .disp_i   (disp_tgt),
        .busy_i   (busy_i),
        .cond_i   (cond_i),
        .upc_nx_o (upc_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = upc_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upc_o  = st_q.upc;
    assign ctrl_o = CTRL_W'(word.ctrl);

    a_r2_next_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word.jump == J_NEXT) |=> (upc_o == $past(upc_o) + 1'b1));

    a_r3_spin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word.jump == J_SPIN && busy_i) |=> $stable(upc_o));

    a_r4_fetch_home: assert property (@(posedge clk) disable iff (!rst_n)
        (word.jump == J_FETCH) |=> (upc_o == '0));

    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_o == HALT_PC) |=> (upc_o == HALT_PC));

    a_r7_ffalse_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (word.jump == J_FFALSE && !cond_i) |=> (upc_o == '0));

    a_r10_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_o == HALT_PC) |-> (ctrl_o == '0));
endmodule

// File: tb/sim_useq_top.sv
module sim_useq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  opcode = 5'd0;
    logic        busy = 1'b0;
    logic        cond = 1'b0;
    logic [5:0]  upc;
    logic [17:0] ctrl;

    int checks = 0;
    int fails  = 0;
    int m_upc  = 0;
    int idx    = 0;
    int limit  = 0;
    int bad_op = 31;
    logic [15:0] lf = 16'hACE1;
    bit finished = 0;
    int prog [8] = '{12, 4, 0, 27, 24, 2, 24, 12};

    useq_top u0 (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .busy_i(busy),
        .cond_i(cond), .upc_o(upc), .ctrl_o(ctrl)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // R8 layout: 0 next, 1 spin, 2 dispatch, 3 fetch, 5 ffalse, 6 park
    function automatic int kind_of(int a);
        case (a)
            0,3,4,6,7,9,10,11,14,15,16,17,19,20,22,23,25,27,29: return 0;
            1,12,26,28,30:                                      return 1;
            2:                                                  return 2;
            5,8,13,18,24,31:                                    return 3;
            21:                                                 return 5;
            default:                                            return 6;
        endcase
    endfunction

    // R5 / R6 mapping
    function automatic int entry_of(int op);
        case (op)
            12: return 3;
            4:  return 6;
            0:  return 9;
            27: return 14;
            24: return 19;
            2:  return 25;
            default: return 32;
        endcase
    endfunction

    string tag = "R1";

    function automatic int step(int a, int op, bit b, bit c, output string t);
        case (kind_of(a))
            0: begin t = "R2 R8"; return a + 1; end
            1: begin t = "R3 R8"; return b ? a : a + 1; end
            2: begin t = (entry_of(op) == 32) ? "R6" : "R5"; return entry_of(op); end
            3: begin t = "R4 R8"; return 0; end
            5: begin t = "R7 R8"; return c ? a + 1 : 0; end
            default: begin t = "R6"; return a; end
        endcase
    endfunction

    task automatic check_ctrl();
        if (m_upc == 0)  chk(ctrl == 18'h30800, "R9 fetch0 ctrl", ctrl, 18'h30800);
        if (m_upc == 1)  chk(ctrl == 18'h04400, "R9 fetch1 ctrl", ctrl, 18'h04400);
        if (m_upc == 30) chk(ctrl == 18'h01260, "R9 add write ctrl", ctrl, 18'h01260);
        if (m_upc == 32) chk(ctrl == 18'h00000, "R10 halt ctrl", ctrl, 0);
    endtask

    task automatic run_cycle();
        @(negedge clk);
        chk(int'(upc) == m_upc, tag, upc, m_upc);
        check_ctrl();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        busy = lf[0] & lf[3];
        cond = lf[5];
        if (m_upc == 2) begin
            opcode = (idx < limit) ? 5'(prog[idx % 8]) : 5'(bad_op);
            idx++;
        end else begin
            opcode = lf[12:8];
        end
        m_upc = step(m_upc, int'(opcode), busy, cond, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_upc = 0;
        tag = "R1";
        repeat (3) begin
            @(negedge clk);
            chk(upc == 6'd0, "R1 reset upc", upc, 0);
            chk(ctrl == 18'h30800, "R1 R9 reset ctrl", ctrl, 18'h30800);
        end
        rst_n = 1'b1;
        busy = 1'b0;
        opcode = 5'd0;
        m_upc = step(0, 0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(upc == 6'd0, "R1 initial reset upc", upc, 0);
        limit = 40; idx = 0; bad_op = 31;
        do_reset();
        repeat (1500) run_cycle();
        chk(int'(upc) == 32, "R6 halted after illegal opcode", upc, 32);
        limit = 20; idx = 0; bad_op = 21;
        do_reset();
        repeat (900) run_cycle();
        chk(int'(upc) == 32, "R6 halted again", upc, 32);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule